// File: doc/BRIEF.md
# Bus Master Memory Command Selector

This block sits in front of a parallel-bus master engine. Each time the engine has a transfer ready, it presents the transfer to the block for one clock. The transfer is described by its direction, its starting byte address and its length in data phases, where one phase is one dword. From that description and three configuration inputs, the block picks which memory command the master will put on the bus. The three configuration inputs are a two-bit read policy, a write-and-invalidate enable and the cache-line size in dwords.

Short reads always use the plain read command. Longer reads follow the read policy, and one policy setting picks the command from the length compared with the cache line. A write is promoted to write-and-invalidate only when the transfer covers whole cache lines from a line boundary. The chosen four-bit command code appears on the clock after the request, with a one-cycle valid strobe. The code then holds until the next request.

Top module: `mstr_cmd_sel`

## Requirements
- R1: While reset is asserted and on the first clock after it is released, cmd_valid is 0 and cmd_code is 4'b0000.
- R2: A request sampled with req_valid=1 on a rising edge gives cmd_valid=1 after that edge, for exactly one cycle per request cycle. Without a request, cmd_valid is 0.
- R3: A read (req_write=0) with req_len of 0, 1 or 2 yields code 4'b0110 (memory read), whatever cfg_rd_policy is.
- R4: A read with req_len > 2 follows cfg_rd_policy. Policy 2'b00 yields 4'b0110 (memory read), 2'b01 yields 4'b1110 (read line) and 2'b10 yields 4'b1100 (read multiple).
- R5: A read with req_len > 2 under policy 2'b11 yields 4'b1100 when req_len is greater than cfg_line_dw, and 4'b1110 otherwise. It also yields 4'b1110 when cfg_line_dw is 0.
- R6: A write yields 4'b1111 (write-and-invalidate) when all four conditions hold: cfg_wi_en=1; cfg_line_dw is a nonzero power of two; req_addr is a multiple of 4*cfg_line_dw bytes; and req_len is greater than cfg_line_dw.
- R7: Every other write yields 4'b0111 (memory write). This covers enable off, a misaligned start, req_len not above the line size, and a line size that is zero or not a power of two.
- R8: cfg_rd_policy has no effect on writes, and cfg_wi_en has no effect on reads.
- R9: While no request is presented, cmd_code keeps the last value it produced.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_valid | input | 1 | A transfer is presented this cycle |
| req_write | input | 1 | 1 = write transfer, 0 = read transfer |
| req_addr | input | ADDR_W | Starting byte address |
| req_len | input | LEN_W | Transfer length in data phases (dwords) |
| cfg_rd_policy | input | 2 | Read command policy for reads longer than two phases |
| cfg_wi_en | input | 1 | Permits write-and-invalidate |
| cfg_line_dw | input | CLS_W | Cache-line size in dwords |
| cmd_valid | output | 1 | One-cycle strobe marking a fresh command |
| cmd_code | output | 4 | Selected bus command code |

## Verification
The block has one register stage. A wrong next-state value therefore shows at the ports on the very next cycle, either as a wrong code or as a strobe that is missing or extra. A wrong decode of alignment, power-of-two line size or length comparison shows only for requests near those edges. For that reason the stimulus walks each boundary from both sides: length equal to the line size and one above it, a start address off by one dword, and line sizes of zero, six and four. A wrong hold path in the register only shows during idle cycles after a request, so the code is also checked after several idle cycles.

// File: rtl/mcs_pkg.sv
package mcs_pkg;

    typedef enum logic [3:0] {
        CMD_NONE    = 4'b0000,
        CMD_MEM_RD  = 4'b0110,
        CMD_MEM_WR  = 4'b0111,
        CMD_RD_MULT = 4'b1100,
        CMD_RD_LINE = 4'b1110,
        CMD_MEM_WRI = 4'b1111
    } bus_cmd_e;

    typedef enum logic [1:0] {
        RDP_PLAIN = 2'b00,
        RDP_LINE  = 2'b01,
        RDP_MULT  = 2'b10,
        RDP_AUTO  = 2'b11
    } rd_policy_e;

    typedef struct packed {
        logic     vld;
        bus_cmd_e cmd;
    } sel_state_t;

    localparam int unsigned SHORT_READ_MAX = 2;

endpackage

// File: rtl/mcs_line_check.sv
// Cache-line geometry of a transfer: line size legality, start alignment and
// whether the length spans more than one line.
module mcs_line_check #(
    parameter int unsigned ADDR_W     = 32,
    parameter int unsigned LEN_W      = 12,
    parameter int unsigned CLS_W      = 8,
    parameter int unsigned PHASE_BYTES = 4
) (
    input  logic [ADDR_W-1:0] addr_i,
    input  logic [LEN_W-1:0]  len_i,
    input  logic [CLS_W-1:0]  line_dw_i,
    output logic              line_nz_o,
    output logic              line_pow2_o,
    output logic              aligned_o,
    output logic              len_gt_line_o
);
    localparam int unsigned OFS_W = (PHASE_BYTES > 1) ? $clog2(PHASE_BYTES) : 0;
    localparam int unsigned DW_W  = ADDR_W - OFS_W;
    localparam int unsigned CMP_W = (LEN_W > CLS_W) ? LEN_W : CLS_W;

    logic [DW_W-1:0]  dw_index;
    logic [DW_W-1:0]  line_mask;
    logic [CLS_W-1:0] line_m1;
    logic             phase_aligned;
    logic [CMP_W-1:0] len_ext;
    logic [CMP_W-1:0] line_ext;

    generate
        if (OFS_W > 0) begin : g_sub_phase
            assign phase_aligned = (addr_i[OFS_W-1:0] == '0);
            assign dw_index      = addr_i[ADDR_W-1:OFS_W];
        end else begin : g_whole_phase
            assign phase_aligned = 1'b1;
            assign dw_index      = addr_i;
        end
    endgenerate

    always_comb begin
        line_m1       = line_dw_i - 1'b1;
        line_mask     = DW_W'(line_m1);
        line_nz_o     = (line_dw_i != '0);
        line_pow2_o   = line_nz_o && ((line_dw_i & line_m1) == '0);
        aligned_o     = phase_aligned && ((dw_index & line_mask) == '0);
        len_ext       = CMP_W'(len_i);
        line_ext      = CMP_W'(line_dw_i);
        len_gt_line_o = (len_ext > line_ext);
    end

endmodule

// File: rtl/mcs_read_pick.sv
// Read command choice from length class and configured policy.
module mcs_read_pick
    import mcs_pkg::*;
#(
    parameter int unsigned LEN_W = 12
) (
    input  logic [LEN_W-1:0] len_i,
    input  logic [1:0]       policy_i,
    input  logic             line_nz_i,
    input  logic             len_gt_line_i,
    output bus_cmd_e         cmd_o
);
    logic       long_read;
    rd_policy_e pol;

    always_comb begin
        long_read = (len_i > LEN_W'(SHORT_READ_MAX));
        pol       = rd_policy_e'(policy_i);
        cmd_o     = CMD_MEM_RD;
        if (long_read) begin
            unique case (pol)
                RDP_PLAIN: cmd_o = CMD_MEM_RD;
                RDP_LINE:  cmd_o = CMD_RD_LINE;
                RDP_MULT:  cmd_o = CMD_RD_MULT;
                RDP_AUTO:  cmd_o = (line_nz_i && len_gt_line_i) ? CMD_RD_MULT
                                                                 : CMD_RD_LINE;
                default:   cmd_o = CMD_MEM_RD;
            endcase
        end
    end

endmodule

// File: rtl/mcs_write_pick.sv
// Write command choice: promotion to write-and-invalidate when whole lines are covered.
module mcs_write_pick
    import mcs_pkg::*;
(
    input  logic     wi_en_i,
    input  logic     line_pow2_i,
    input  logic     aligned_i,
    input  logic     len_gt_line_i,
    output bus_cmd_e cmd_o
);
    logic promote;

    always_comb begin
        promote = wi_en_i && line_pow2_i && aligned_i && len_gt_line_i;
        cmd_o   = promote ? CMD_MEM_WRI : CMD_MEM_WR;
    end

endmodule

// File: rtl/mstr_cmd_sel.sv
module mstr_cmd_sel
    import mcs_pkg::*;
#(
    parameter int unsigned ADDR_W = 32,
    parameter int unsigned LEN_W  = 12,
    parameter int unsigned CLS_W  = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              req_valid,
    input  logic              req_write,
    input  logic [ADDR_W-1:0] req_addr,
    input  logic [LEN_W-1:0]  req_len,
    input  logic [1:0]        cfg_rd_policy,
    input  logic              cfg_wi_en,
    input  logic [CLS_W-1:0]  cfg_line_dw,
    output logic              cmd_valid,
    output logic [3:0]        cmd_code
);
    localparam sel_state_t RESET_STATE = '{vld: 1'b0, cmd: CMD_NONE};

    logic       line_nz;
    logic       line_pow2;
    logic       aligned;
    logic       len_gt_line;
    bus_cmd_e   rd_cmd;
    bus_cmd_e   wr_cmd;
    sel_state_t state_d;
    sel_state_t state_q;

    mcs_line_check #(
        .ADDR_W      (ADDR_W),
        .LEN_W       (LEN_W),
        .CLS_W       (CLS_W),
        .PHASE_BYTES (4)
    ) i_line (
        .addr_i        (req_addr),
        .len_i         (req_len),
        .line_dw_i     (cfg_line_dw),
        .line_nz_o     (line_nz),
        .line_pow2_o   (line_pow2),
        .aligned_o     (aligned),
        .len_gt_line_o (len_gt_line)
    );

    mcs_read_pick #(
        .LEN_W (LEN_W)
    ) i_rd (
        .len_i         (req_len),
        .policy_i      (cfg_rd_policy),
        .line_nz_i     (line_nz),
        .len_gt_line_i (len_gt_line),
        .cmd_o         (rd_cmd)
    );

    mcs_write_pick i_wr (
        .wi_en_i       (cfg_wi_en),
        .line_pow2_i   (line_pow2),
        .aligned_i     (aligned),
        .len_gt_line_i (len_gt_line),
        .cmd_o         (wr_cmd)
    );

    always_comb begin
        state_d     = state_q;
        state_d.vld = req_valid;
        if (req_valid) begin
            state_d.cmd = req_write ? wr_cmd : rd_cmd;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= RESET_STATE;
        end else begin
            state_q <= state_d;
        end
    end

    assign cmd_valid = state_q.vld;
    assign cmd_code  = state_q.cmd;

endmodule

// File: rtl/mstr_cmd_sel_chk.sv
module mstr_cmd_sel_chk #(
    parameter int unsigned LEN_W = 12
) (
    input logic             clk,
    input logic             rst_n,
    input logic             req_valid,
    input logic             req_write,
    input logic [LEN_W-1:0] req_len,
    input logic             cfg_wi_en,
    input logic             cmd_valid,
    input logic [3:0]       cmd_code
);
    a_r2_strobe_after_req: assert property (@(posedge clk) disable iff (!rst_n)
        req_valid |=> cmd_valid);

    a_r2_no_strobe_idle: assert property (@(posedge clk) disable iff (!rst_n)
        !req_valid |=> !cmd_valid);

    a_r3_short_read_plain: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && !req_write && (req_len <= LEN_W'(2))) |=> (cmd_code == 4'b0110));

    a_r7_wi_off_plain_write: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && req_write && !cfg_wi_en) |=> (cmd_code == 4'b0111));

    a_r8_read_codes_only: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && !req_write) |=>
            (cmd_code == 4'b0110 || cmd_code == 4'b1110 || cmd_code == 4'b1100));

    a_r6_write_codes_only: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && req_write) |=> (cmd_code == 4'b0111 || cmd_code == 4'b1111));

    a_r9_code_holds: assert property (@(posedge clk) disable iff (!rst_n)
        !req_valid |=> $stable(cmd_code));

endmodule

bind mstr_cmd_sel mstr_cmd_sel_chk #(.LEN_W(LEN_W)) i_mstr_cmd_sel_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .req_valid (req_valid),
    .req_write (req_write),
    .req_len   (req_len),
    .cfg_wi_en (cfg_wi_en),
    .cmd_valid (cmd_valid),
    .cmd_code  (cmd_code)
);

// File: tb/test_mstr_cmd_sel.sv
`timescale 1ns/1ps
module test_mstr_cmd_sel;
    localparam int ADDR_W = 32;
    localparam int LEN_W  = 12;
    localparam int CLS_W  = 8;
    localparam int VEC_W  = 1 + 32 + 12 + 2 + 1 + 8 + 4;
    localparam int NVEC   = 19;

    // {write, addr, len, policy, wi_en, line_dw, expected code}
    localparam logic [VEC_W-1:0] VECS [0:NVEC-1] = '{
        {1'b0, 32'h0000_1000, 12'd1,  2'b10, 1'b0, 8'd8, 4'b0110}, // R3
        {1'b0, 32'h0000_1004, 12'd2,  2'b01, 1'b0, 8'd8, 4'b0110}, // R3
        {1'b0, 32'h0000_1000, 12'd0,  2'b11, 1'b0, 8'd8, 4'b0110}, // R3
        {1'b0, 32'h0000_1000, 12'd3,  2'b00, 1'b0, 8'd8, 4'b0110}, // R4
        {1'b0, 32'h0000_1000, 12'd3,  2'b01, 1'b0, 8'd8, 4'b1110}, // R4
        {1'b0, 32'h0000_1000, 12'd3,  2'b10, 1'b0, 8'd8, 4'b1100}, // R4
        {1'b0, 32'h0000_1000, 12'd8,  2'b11, 1'b0, 8'd8, 4'b1110}, // R5
        {1'b0, 32'h0000_1000, 12'd9,  2'b11, 1'b0, 8'd8, 4'b1100}, // R5
        {1'b0, 32'h0000_1000, 12'd9,  2'b11, 1'b0, 8'd0, 4'b1110}, // R5
        {1'b1, 32'h0000_1000, 12'd9,  2'b00, 1'b1, 8'd8, 4'b1111}, // R6
        {1'b1, 32'h0000_1020, 12'd16, 2'b11, 1'b1, 8'd8, 4'b1111}, // R8
        {1'b1, 32'h0000_1000, 12'd8,  2'b00, 1'b1, 8'd8, 4'b0111}, // R7
        {1'b1, 32'h0000_1004, 12'd16, 2'b00, 1'b1, 8'd8, 4'b0111}, // R7
        {1'b1, 32'h0000_1000, 12'd16, 2'b00, 1'b0, 8'd8, 4'b0111}, // R7
        {1'b1, 32'h0000_1000, 12'd16, 2'b00, 1'b1, 8'd6, 4'b0111}, // R7
        {1'b1, 32'h0000_1000, 12'd16, 2'b00, 1'b1, 8'd0, 4'b0111}, // R7
        {1'b0, 32'h0000_1000, 12'd16, 2'b10, 1'b1, 8'd8, 4'b1100}, // R8
        {1'b1, 32'h0000_1010, 12'd9,  2'b00, 1'b1, 8'd4, 4'b1111}, // R6
        {1'b0, 32'h0000_1000, 12'd7,  2'b11, 1'b0, 8'd6, 4'b1100}  // R5
    };

    logic              clk = 1'b0;
    logic              rst_n = 1'b0;
    logic              req_valid = 1'b0;
    logic              req_write = 1'b0;
    logic [ADDR_W-1:0] req_addr = '0;
    logic [LEN_W-1:0]  req_len = '0;
    logic [1:0]        cfg_rd_policy = '0;
    logic              cfg_wi_en = 1'b0;
    logic [CLS_W-1:0]  cfg_line_dw = '0;
    logic              cmd_valid;
    logic [3:0]        cmd_code;

    int n_checks = 0;
    int n_fail   = 0;
    bit done     = 1'b0;

    always #4 clk = ~clk;

    mstr_cmd_sel #(.ADDR_W(ADDR_W), .LEN_W(LEN_W), .CLS_W(CLS_W)) i_mstr_cmd_sel (
        .clk           (clk),
        .rst_n         (rst_n),
        .req_valid     (req_valid),
        .req_write     (req_write),
        .req_addr      (req_addr),
        .req_len       (req_len),
        .cfg_rd_policy (cfg_rd_policy),
        .cfg_wi_en     (cfg_wi_en),
        .cfg_line_dw   (cfg_line_dw),
        .cmd_valid     (cmd_valid),
        .cmd_code      (cmd_code)
    );

    task automatic check(input string req, input logic [3:0] act, input logic [3:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %b expected %b", req, act, exp);
        end
    endtask

    task automatic load(input logic [VEC_W-1:0] v);
        req_write     = v[59];
        req_addr      = v[58:27];
        req_len       = v[26:15];
        cfg_rd_policy = v[14:13];
        cfg_wi_en     = v[12];
        cfg_line_dw   = v[11:4];
    endtask

    initial begin
        logic [3:0] held;
        @(negedge clk);
        check("R1 valid in reset", {3'b0, cmd_valid}, 4'b0000);
        check("R1 code in reset", cmd_code, 4'b0000);
        rst_n = 1'b1;
        @(negedge clk);
        check("R1 valid after release", {3'b0, cmd_valid}, 4'b0000);
        check("R1 code after release", cmd_code, 4'b0000);

        // table walk: one request, one idle cycle
        for (int i = 0; i < NVEC; i++) begin
            load(VECS[i]);
            req_valid = 1'b1;
            @(negedge clk);
            req_valid = 1'b0;
            check("R2 strobe", {3'b0, cmd_valid}, 4'b0001);
            check("R3-R8 table code", cmd_code, VECS[i][3:0]);
            @(negedge clk);
            check("R2 strobe drops", {3'b0, cmd_valid}, 4'b0000);
        end

        // R9: code held over idle cycles, with inputs changing
        held = cmd_code;
        req_write = 1'b1; cfg_wi_en = 1'b1; req_len = 12'd64;
        repeat (4) @(negedge clk);
        check("R9 code holds", cmd_code, held);
        check("R9 valid low", {3'b0, cmd_valid}, 4'b0000);

        // R2: back-to-back requests, one strobe per request cycle
        load(VECS[9]);
        req_valid = 1'b1;
        @(negedge clk);
        check("R2 back-to-back first", cmd_code, 4'b1111);
        load(VECS[5]);
        @(negedge clk);
        check("R2 back-to-back second", cmd_code, 4'b1100);
        check("R2 back-to-back valid", {3'b0, cmd_valid}, 4'b0001);
        req_valid = 1'b0;
        @(negedge clk);
        check("R2 valid after burst", {3'b0, cmd_valid}, 4'b0000);

        // R8: write with every policy value stays plain when not promoted
        for (int p = 0; p < 4; p++) begin
            load(VECS[13]);
            cfg_rd_policy = 2'(p);
            req_valid = 1'b1;
            @(negedge clk);
            req_valid = 1'b0;
            check("R8 policy ignored on write", cmd_code, 4'b0111);
        end

        // R1: reset mid-run clears state
        rst_n = 1'b0;
        @(negedge clk);
        check("R1 code cleared", cmd_code, 4'b0000);
        rst_n = 1'b1;
        @(negedge clk);
        done = 1'b1;
    end

    initial begin
        repeat (5000) @(posedge clk);
        if (!done) begin
            n_checks++;
            n_fail++;
            $display("FAIL watchdog: actual running expected done");
        end
    end

    initial begin
        wait (done);
        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
        $finish;
    end

    initial begin
        repeat (5001) @(posedge clk);
        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
        $finish;
    end

endmodule